// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block lets a clocked system read and write an external 2048 x 8 asynchronous static RAM. A single request carries a direction flag, an 11-bit location and a write byte. The block then drives the memory's select, output-enable and write strobes, the address lines and a shared data bus. The bus is split into an output value, an input value and a driver enable. Reads return one byte with a one-cycle valid strobe.

Every phase of an access is counted in clock ticks. Each count is computed at elaboration as the ceiling of a nanosecond minimum divided by the clock period parameter. The phases are address setup, write strobe, data hold, recovery, read access and bus release. On writes the output-enable strobe stays high, so the memory never drives the pins while the controller does.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, select, output-enable and write strobes are high (inactive), the data driver enable is low, ready is high and read-valid is low.
- R2: A read returns the byte stored at the requested location. Read-valid is high for exactly one cycle per read, with the byte on the read data output in that cycle.
- R3: A write stores the request byte at the requested location, captured when the write strobe rises.
- R4: The write strobe is low only while select is low, and output-enable is high whenever the write strobe is low. Output-enable is low only while select is low.
- R5: The address lines do not change while select stays low.
- R6: The write strobe stays low for at least ceil(25 ns / period) cycles. Ready stays low for at least ceil(70 ns / period) cycles from the accepting edge of a write.
- R7: Write data is driven and unchanged for at least ceil(20 ns / period) cycles before the write strobe rises, and it is still driven in the cycle after the rise.
- R8: The write strobe falls no sooner than ceil(20 ns / period) cycles after the address and select were applied.
- R9: Read data is captured only after select and output-enable have been low, with a stable address, for at least ceil(70 ns / period) cycles.
- R10: The data driver enable is never high while output-enable is low.
- R11: Ready is low from the accepting edge until the access completes. A request raised while ready is low is ignored.
- R12: After a read, output-enable and select stay high for at least ceil(30 ns / period) cycles before ready rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, taken when ready_o is high |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 11 | Word location |
| wdata_i | input | 8 | Write byte |
| ready_o | output | 1 | Idle and able to accept a request |
| rdata_o | output | 8 | Read byte |
| rvalid_o | output | 1 | One-cycle strobe for rdata_o |
| sram_cs_no | output | 1 | Memory select, active low |
| sram_oe_no | output | 1 | Memory output enable, active low |
| sram_we_no | output | 1 | Memory write strobe, active low |
| sram_addr_o | output | 11 | Memory address lines |
| sram_dq_o | output | 8 | Data value driven toward the memory |
| sram_dq_i | input | 8 | Data value seen on the memory pins |
| sram_dq_oe_o | output | 1 | Enable for the controller's data drivers |

## Verification
A wrong phase count shows up at the strobe pins within the same access. A short strobe or setup window appears at the edge where the write strobe moves. A short read wait returns stale bytes on the next valid strobe. A short release window shows as ready rising too early after a read. A stuck or skipped state shows up as a missing or doubled valid pulse, as a write that a later read of the same location does not reflect, or as ready failing to return, which the watchdog reports.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD_SETUP,
    ST_RD_WAIT,
    ST_RD_CAPTURE,
    ST_RD_TURNOFF,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_HOLD,
    ST_WR_RECOVER
  } ctrl_state_e;

  // ceil(ns / period), never below one tick
  function automatic int ticks(input int ns, input int period);
    int t;
    t = (ns + period - 1) / period;
    return (t < 1) ? 1 : t;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          cnt_q <= '0;
    else if (load_i)      cnt_q <= load_val_i;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

endmodule

// File: rtl/sram_dq_path.sv
module sram_dq_path #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          drive_d_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          cap_i,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dq_o    <= '0;
      dq_oe_o <= 1'b0;
    end else begin
      dq_oe_o <= drive_d_i;
      if (drive_d_i) dq_o <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= cap_i;
      if (cap_i) rdata_o <= dq_i;
    end
  end

  AST_RVALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o) else $error("rvalid longer than one cycle"); // R2

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW            = 11,
  parameter int DW            = 8,
  parameter int CLK_PERIOD_NS = 5,
  parameter int T_ADDR_SU_NS  = 20,
  parameter int T_WPULSE_NS   = 25,
  parameter int T_DSU_NS      = 20,
  parameter int T_DHOLD_NS    = 5,
  parameter int T_WREC_NS     = 5,
  parameter int T_WCYC_NS     = 70,
  parameter int T_ACC_NS      = 70,
  parameter int T_OEACC_NS    = 40,
  parameter int T_RCYC_NS     = 70,
  parameter int T_OFF_NS      = 30
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ready_o,
  output logic [DW-1:0] rdata_o,
  output logic          rvalid_o,
  output logic          sram_cs_no,
  output logic          sram_oe_no,
  output logic          sram_we_no,
  output logic [AW-1:0] sram_addr_o,
  output logic [DW-1:0] sram_dq_o,
  input  logic [DW-1:0] sram_dq_i,
  output logic          sram_dq_oe_o
);

  localparam int AS_T  = ticks(T_ADDR_SU_NS, CLK_PERIOD_NS);
  localparam int PUL_T = imax(ticks(T_WPULSE_NS, CLK_PERIOD_NS), ticks(T_DSU_NS, CLK_PERIOD_NS));
  localparam int DH_T  = ticks(T_DHOLD_NS, CLK_PERIOD_NS);
  localparam int WC_T  = ticks(T_WCYC_NS, CLK_PERIOD_NS);
  localparam int REC_T = imax(ticks(T_WREC_NS, CLK_PERIOD_NS), WC_T - AS_T - PUL_T - DH_T);
  localparam int RDW_T = imax(imax(ticks(T_ACC_NS, CLK_PERIOD_NS), ticks(T_OEACC_NS, CLK_PERIOD_NS)),
                              ticks(T_RCYC_NS, CLK_PERIOD_NS) - 1);
  localparam int OFF_T = ticks(T_OFF_NS, CLK_PERIOD_NS);
  localparam int MAX_T = imax(imax(imax(AS_T, PUL_T), imax(DH_T, REC_T)), imax(RDW_T, OFF_T));
  localparam int CNT_W = $clog2(MAX_T + 1);

  ctrl_state_e      state_q, state_d;
  logic             tmr_load, tmr_done;
  logic [CNT_W-1:0] tmr_val;
  logic [DW-1:0]    wdata_q;
  logic             accept;

  assign accept = (state_q == ST_IDLE) && req_i;

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .done_o     (tmr_done)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        tmr_load = 1'b1;
        if (wr_i) begin
          state_d = ST_WR_SETUP;
          tmr_val = CNT_W'(AS_T - 1);
        end else begin
          state_d = ST_RD_SETUP;
        end
      end
      ST_RD_SETUP: if (tmr_done) begin
        state_d  = ST_RD_WAIT;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(RDW_T - 1);
      end
      ST_RD_WAIT: if (tmr_done) begin
        state_d  = ST_RD_CAPTURE;
        tmr_load = 1'b1;
      end
      ST_RD_CAPTURE: begin
        state_d  = ST_RD_TURNOFF;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(OFF_T - 1);
      end
      ST_RD_TURNOFF: if (tmr_done) state_d = ST_IDLE;
      ST_WR_SETUP: if (tmr_done) begin
        state_d  = ST_WR_PULSE;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(PUL_T - 1);
      end
      ST_WR_PULSE: if (tmr_done) begin
        state_d  = ST_WR_HOLD;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(DH_T - 1);
      end
      ST_WR_HOLD: if (tmr_done) begin
        state_d  = ST_WR_RECOVER;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(REC_T - 1);
      end
      ST_WR_RECOVER: if (tmr_done) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  // strobes are registered decodes of the next state: glitch-free at the pins
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      ready_o     <= 1'b1;
      sram_cs_no  <= 1'b1;
      sram_oe_no  <= 1'b1;
      sram_we_no  <= 1'b1;
      sram_addr_o <= '0;
      wdata_q     <= '0;
    end else begin
      state_q    <= state_d;
      ready_o    <= (state_d == ST_IDLE);
      sram_cs_no <= (state_d == ST_IDLE) || (state_d == ST_RD_TURNOFF) ||
                    (state_d == ST_WR_RECOVER);
      sram_oe_no <= !((state_d == ST_RD_WAIT) || (state_d == ST_RD_CAPTURE));
      sram_we_no <= (state_d != ST_WR_PULSE);
      if (accept) begin
        sram_addr_o <= addr_i;
        wdata_q     <= wdata_i;
      end
    end
  end

  sram_dq_path #(.DW(DW)) u_dq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .drive_d_i ((state_d == ST_WR_PULSE) || (state_d == ST_WR_HOLD)),
    .wdata_i   (wdata_q),
    .cap_i     ((state_q == ST_RD_WAIT) && tmr_done),
    .dq_i      (sram_dq_i),
    .dq_o      (sram_dq_o),
    .dq_oe_o   (sram_dq_oe_o),
    .rdata_o   (rdata_o),
    .rvalid_o  (rvalid_o)
  );

  AST_WE_NEEDS_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> !sram_cs_no) else $error("write strobe without select"); // R4
  AST_OE_HIGH_IN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_we_no |-> sram_oe_no) else $error("output enable low during write"); // R4
  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sram_dq_oe_o |-> sram_oe_no) else $error("bus contention"); // R10
  AST_ADDR_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sram_cs_no && !$past(sram_cs_no)) |-> $stable(sram_addr_o)) else $error("address moved"); // R5
  AST_DATA_AT_WE_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sram_we_no) |-> (sram_dq_oe_o && $stable(sram_dq_o))) else $error("data not held"); // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sram_cs_no |-> !ready_o) else $error("ready during access"); // R11

endmodule

// File: tb/sram_async_ctrl_test.sv
module sram_async_ctrl_test;

  function automatic int cdiv(input int ns);
    return (ns + 4) / 5;
  endfunction

  localparam int AS_T  = cdiv(20);
  localparam int WP_T  = cdiv(25);
  localparam int DW_T  = cdiv(20);
  localparam int WC_T  = cdiv(70);
  localparam int AA_T  = cdiv(70);
  localparam int OFF_T = cdiv(30);

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, wr_i = 1'b0;
  logic [10:0] addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic        ready_o, rvalid_o;
  logic [7:0]  rdata_o;
  logic        sram_cs_no, sram_oe_no, sram_we_no, sram_dq_oe_o;
  logic [10:0] sram_addr_o;
  logic [7:0]  sram_dq_o, sram_dq_i;

  int errors = 0, checks = 0;
  logic done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  sram_async_ctrl uut (
    .clk_i, .rst_ni, .req_i, .wr_i, .addr_i, .wdata_i, .ready_o, .rdata_o, .rvalid_o,
    .sram_cs_no, .sram_oe_no, .sram_we_no, .sram_addr_o, .sram_dq_o, .sram_dq_i, .sram_dq_oe_o
  );

  // memory model
  logic [7:0] mem [2048];
  logic [7:0] exp_mem [2048];
  int  rd_age = 0;
  logic mdrive;
  assign mdrive = !sram_cs_no && !sram_oe_no && sram_we_no;
  assign sram_dq_i = !mdrive ? 8'h00 :
                     (rd_age >= AA_T) ? mem[sram_addr_o] : ~mem[sram_addr_o];

  always @(posedge sram_we_no)
    if (sram_cs_no === 1'b0)
      mem[sram_addr_o] <= (sram_dq_oe_o === 1'b1) ? sram_dq_o : 8'h5A;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // pin monitor
  logic        p_cs = 1, p_oe = 1, p_we = 1, p_ready = 1, p_dqoe = 0, last_rd = 0;
  logic [10:0] p_addr = '0;
  logic [7:0]  p_dq = '0;
  int addr_age = 0, we_run = 0, dq_run = 0, oe_age = 0;

  always @(negedge clk_i) if (rst_ni && !done) begin
    if (mdrive) rd_age = (p_addr == sram_addr_o && !p_cs && !p_oe && p_we) ? rd_age + 1 : 1;
    else rd_age = 0;
    addr_age = (!sram_cs_no && !p_cs && sram_addr_o == p_addr) ? addr_age + 1 : 0;
    dq_run   = (sram_dq_oe_o && p_dqoe && sram_dq_o == p_dq) ? dq_run + 1 : (sram_dq_oe_o ? 1 : 0);
    oe_age   = sram_oe_no ? oe_age + 1 : 0;
    if (!sram_we_no && p_we)
      chk(addr_age >= AS_T, "R8 address setup", addr_age, AS_T);
    if (!sram_we_no) we_run++;
    if (sram_we_no && !p_we) begin
      chk(we_run >= WP_T, "R6 strobe width", we_run, WP_T);
      chk(p_dqoe && dq_run - 1 >= DW_T, "R7 data setup", dq_run - 1, DW_T);
      chk(sram_dq_oe_o, "R7 data hold", sram_dq_oe_o, 1);
      we_run = 0;
    end
    chk(sram_we_no || (!sram_cs_no && sram_oe_no), "R4 strobe mode", {sram_cs_no, sram_oe_no, sram_we_no}, 3'b010);
    chk(sram_oe_no || !sram_cs_no, "R4 oe needs cs", sram_cs_no, 0);
    chk(!(sram_dq_oe_o && !sram_oe_no), "R10 contention", sram_dq_oe_o, 0);
    if (!sram_cs_no && !p_cs)
      chk(sram_addr_o == p_addr, "R5 address stable", sram_addr_o, p_addr);
    if (!sram_cs_no) chk(!ready_o, "R11 busy ready", ready_o, 0);
    if (rvalid_o) begin
      chk(rd_age >= AA_T, "R9 access wait", rd_age, AA_T);
      last_rd = 1;
    end
    if (ready_o && !p_ready) begin
      if (last_rd) chk(oe_age > OFF_T, "R12 release window", oe_age - 1, OFF_T);
      last_rd = 0;
    end
    p_cs = sram_cs_no; p_oe = sram_oe_no; p_we = sram_we_no; p_ready = ready_o;
    p_addr = sram_addr_o; p_dq = sram_dq_o; p_dqoe = sram_dq_oe_o;
  end

  task automatic access(input logic wr, input logic [10:0] a, input logic [7:0] d, input int noise);
    int busy = 0, nval = 0;
    logic [7:0] got = '0;
    @(negedge clk_i);
    while (!ready_o) @(negedge clk_i);
    req_i = 1; wr_i = wr; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    chk(!ready_o, "R11 accept", ready_o, 0);
    req_i = 0;
    while (!ready_o) begin
      busy++;
      if (busy <= noise) begin  // R11: request during busy must be ignored
        req_i = 1; wr_i = 1; addr_i = a ^ 11'h7FF; wdata_i = ~d;
      end else req_i = 0;
      if (rvalid_o) begin nval++; got = rdata_o; end
      @(negedge clk_i);
    end
    req_i = 0;
    if (wr) begin
      chk(busy >= WC_T, "R6 write cycle", busy, WC_T);
      exp_mem[a] = d;
    end else begin
      chk(nval == 1, "R2 one valid", nval, 1);
      chk(got == exp_mem[a], "R2 R3 read data", got, exp_mem[a]);
    end
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) begin
      mem[i] = 8'((i * 37) ^ (i >> 3));
      exp_mem[i] = 8'((i * 37) ^ (i >> 3));
    end
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    chk(sram_cs_no && sram_oe_no && sram_we_no && !sram_dq_oe_o && ready_o && !rvalid_o,
        "R1 reset state", {sram_cs_no, sram_oe_no, sram_we_no, sram_dq_oe_o, ready_o, rvalid_o}, 6'b111010);
    rst_ni = 1;
    access(0, 11'd0, 8'h00, 0);           // R2 preset contents
    access(1, 11'd0, 8'hFF, 0);           // R3 lowest location
    access(0, 11'd0, 8'h00, 0);
    access(1, 11'd2047, 8'h00, 0);        // R3 highest location
    access(0, 11'd2047, 8'h00, 0);
    access(1, 11'd100, 8'hC3, 3);         // R11 noise while busy
    access(0, 11'd100 ^ 11'h7FF, 8'h00, 0);
    access(0, 11'd100, 8'h00, 5);
    access(1, 11'd5, 8'h11, 0);           // back-to-back writes then reads
    access(1, 11'd6, 8'h22, 0);
    access(0, 11'd6, 8'h00, 0);
    access(0, 11'd5, 8'h00, 0);
    for (int n = 0; n < 400; n++) begin
      logic [10:0] a = 11'($urandom);
      if (n % 4 == 0) a = 11'($urandom % 16);
      access(1'($urandom), a, 8'($urandom), 0);
    end
    repeat (4) @(negedge clk_i);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL R11 watchdog actual=hang expected=idle");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule